// File: doc/BRIEF.md
# Serial Peripheral Master, Idle-High Clock, Sample-on-Fall Framing

This block is a synchronous serial master for the clock mode in which SCK rests high and data is captured on its falling edges. Words of 4 to 16 bits are queued in an 8-entry transmit FIFO. Each word goes out MSB first on MOSI while the bits returned on MISO are gathered into an 8-entry receive FIFO. Slave select is active low and brackets every word, so a stream of queued words is sent as separate frames with a deselect pulse between each pair.

All frame timing is counted in half periods of SCK. One half period lasts (divider+1) system clocks. Configuration (enable, divider, word length) arrives on plain input ports. The divider and word length are captured when a frame starts, so they may be changed while a frame is in flight. Dropping the enable input stops a frame at once.

Top module: `spi_frame_master`

## Requirements
- R1: While enable is low or no frame is active, ssN=1, sck=1 and mosiOe=0 (MOSI released); mosiOe=1 and busy=1 exactly while ssN=0.
- R2: A frame begins (ssN falls) only when enable=1 and the transmit FIFO is not empty; with an empty FIFO ssN stays high.
- R3: The first falling edge of sck comes two half periods after ssN falls. MOSI is held at 0 for the first half period and shows the MSB for the second.
- R4: Bits travel MSB first. MISO is sampled at each falling sck edge, and MOSI advances at each rising sck edge, so the word on MOSI and the word captured from MISO each hold exactly the word-length number of bits.
- R5: The wordLen input (5 bits) selects 4..16 bits per word. Values below 4 act as 4 and values above 16 act as 16. A received word is right-justified with zeros in the unused upper bits.
- R6: ssN rises two half periods (one SCK period) after the falling sck edge that samples the last bit.
- R7: When words are queued back to back, ssN stays high for exactly two half periods between frames and then the next frame begins.
- R8: A half period is (divider+1) system clocks, with divider=0 treated as 1. A change to divider during a frame has no effect on that frame.
- R9: The transmit FIFO holds 8 words. txFull is set with 8 words queued, and a write while full is ignored. txEmpty shows no queued word.
- R10: The receive FIFO holds 8 words and presents its oldest word on rxData; rxRead removes it. A word that completes while the FIFO is full is dropped and sets rxOverrun, which stays set until enable is low.
- R11: Clearing enable during a frame returns ssN, sck, mosiOe and busy to idle in the same cycle, and the partial word is not written to the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and idles |
| divider | input | 8 | Half-period setting, half period = divider+1 clocks |
| wordLen | input | 5 | Bits per word, 4..16 |
| txData | input | 16 | Word to queue, right-justified |
| txWrite | input | 1 | Push txData into the transmit FIFO |
| txFull | output | 1 | Transmit FIFO full |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxData | output | 16 | Oldest received word |
| rxRead | input | 1 | Remove the oldest received word |
| rxFull | output | 1 | Receive FIFO full |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxOverrun | output | 1 | Sticky: a received word was dropped |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Output enable for MOSI, 0 means released |
| ssN | output | 1 | Slave select, active low |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A frame is active |

## Verification
The hardest case to reach is a receive overrun, because the receive FIFO must fill while one more frame is still able to start. The stimulus queues nine words with the block disabled, so the ninth write also meets a full transmit FIFO. It then enables the block, lets eight frames fill the receive side, and queues one extra word. The test then checks that the flag sets and that the eight stored words are intact and in order. A second hard case is an abort in the middle of a word. The bench waits for a real falling sck edge inside a long 16-bit frame before it drops enable, and then confirms that no partial word reaches the receive FIFO.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  // strobes from the sequencer to the datapath, all single-cycle
  typedef struct packed {
    logic load;    // pop transmit word, clear receive shifter
    logic sample;  // capture miso (falling sck)
    logic shift;   // advance mosi (rising sck)
    logic push;    // hand the finished word to the receive FIFO
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PRESET, ST_LOW, ST_HIGH, ST_TRAIL, ST_GAP
  } seq_state_t;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic wrEn, rdEn;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wrEn  = push && !full;
  assign rdEn  = pop && !empty;
  assign head  = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      if (wrEn && !rdEn) count <= count + 1'b1;
      else if (rdEn && !wrEn) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/spi_fm_ctrl.sv
module spi_fm_ctrl
  import spi_fm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divider,
  input  logic [LEN_W-1:0] wordLen,
  input  logic             txEmpty,
  output strobe_t          strb,
  output logic [IDX_W-1:0] lenM1,
  output logic             mosiHold,
  output logic             sck,
  output logic             ssN,
  output logic             mosiOe,
  output logic             busy
);
  localparam int CNT_W = DIV_W + 2;

  seq_state_t state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [DIV_W:0]   halfQ, halfNew;
  logic [LEN_W-1:0] bitsLeft, lenEff;
  logic startOk, phaseEnd, inFrame;

  assign startOk  = enable && !txEmpty;
  assign phaseEnd = (cnt == '0);

  always_comb begin
    if (wordLen < LEN_W'(MIN_LEN))      lenEff = LEN_W'(MIN_LEN);
    else if (wordLen > LEN_W'(DATA_W))  lenEff = LEN_W'(DATA_W);
    else                                lenEff = wordLen;
    halfNew = (divider == '0) ? (DIV_W + 1)'(2) : {1'b0, divider} + 1'b1;
  end

  always_comb begin
    strb   = '0;
    nState = state;
    nCnt   = cnt - 1'b1;
    case (state)
      ST_IDLE: begin
        nCnt = '0;
        if (startOk) begin
          strb.load = 1'b1;
          nState = ST_SETUP;
          nCnt = CNT_W'(halfNew) - 1'b1;
        end
      end
      ST_SETUP: if (phaseEnd) begin
        nState = ST_PRESET;
        nCnt = CNT_W'(halfQ) - 1'b1;
      end
      ST_PRESET, ST_HIGH: if (phaseEnd) begin
        nState = ST_LOW;
        strb.sample = 1'b1;
        nCnt = CNT_W'(halfQ) - 1'b1;
      end
      ST_LOW: if (phaseEnd) begin
        nCnt = CNT_W'(halfQ) - 1'b1;
        if (bitsLeft == LEN_W'(1)) begin
          nState = ST_TRAIL;
          strb.push = 1'b1;
        end else begin
          nState = ST_HIGH;
          strb.shift = 1'b1;
        end
      end
      ST_TRAIL: if (phaseEnd) begin
        nState = ST_GAP;
        nCnt = (CNT_W'(halfQ) << 1) - 1'b1;
      end
      ST_GAP: if (phaseEnd) begin
        if (startOk) begin
          strb.load = 1'b1;
          nState = ST_SETUP;
          nCnt = CNT_W'(halfNew) - 1'b1;
        end else begin
          nState = ST_IDLE;
          nCnt = '0;
        end
      end
      default: nState = ST_IDLE;
    endcase
    if (!enable) strb = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      halfQ    <= (DIV_W + 1)'(2);
      bitsLeft <= '0;
      lenM1    <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nState;
      cnt   <= nCnt;
      if (strb.load) begin
        halfQ    <= halfNew;
        lenM1    <= IDX_W'(lenEff - 1'b1);
        bitsLeft <= lenEff;
      end else if (strb.shift || strb.push) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  assign inFrame  = enable && (state inside {ST_SETUP, ST_PRESET, ST_LOW, ST_HIGH, ST_TRAIL});
  assign ssN      = !inFrame;
  assign busy     = inFrame;
  assign mosiOe   = inFrame;
  assign sck      = !(enable && state == ST_LOW);
  assign mosiHold = (state == ST_SETUP);
endmodule

// File: rtl/spi_fm_data.sv
module spi_fm_data
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  lenM1,
  input  logic              mosiHold,
  input  logic              miso,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  output logic              mosi,
  output logic              txFull,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              rxOverrun
);
  logic [DATA_W-1:0] txHead, txShift, rxShift;

  spi_fm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .push(txWrite), .wrData(txData),
    .pop(strb.load), .head(txHead), .full(txFull), .empty(txEmpty)
  );

  spi_fm_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .push(strb.push), .wrData(rxShift),
    .pop(rxRead), .head(rxData), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (strb.load)       txShift <= txHead;
      else if (strb.shift) txShift <= txShift << 1;
      if (strb.load)        rxShift <= '0;
      else if (strb.sample) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (!enable)                    rxOverrun <= 1'b0;
      else if (strb.push && rxFull)   rxOverrun <= 1'b1;
    end
  end

  assign mosi = mosiHold ? 1'b0 : txShift[lenM1];
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  parameter int DEPTH   = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divider,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              txFull,
  output logic              txEmpty,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxRead,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic              rxOverrun,
  output logic              sck,
  output logic              mosi,
  output logic              mosiOe,
  output logic              ssN,
  input  logic              miso,
  output logic              busy
);
  strobe_t strb;
  logic [IDX_W-1:0] lenM1;
  logic mosiHold;

  spi_fm_ctrl #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .DIV_W(DIV_W)) ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider),
    .wordLen(wordLen), .txEmpty(txEmpty), .strb(strb), .lenM1(lenM1),
    .mosiHold(mosiHold), .sck(sck), .ssN(ssN), .mosiOe(mosiOe), .busy(busy)
  );

  spi_fm_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb), .lenM1(lenM1),
    .mosiHold(mosiHold), .miso(miso), .txData(txData), .txWrite(txWrite),
    .rxRead(rxRead), .mosi(mosi), .txFull(txFull), .txEmpty(txEmpty),
    .rxData(rxData), .rxFull(rxFull), .rxEmpty(rxEmpty), .rxOverrun(rxOverrun)
  );
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txEmpty,
  input logic txFull,
  input logic rxFull,
  input logic rxOverrun,
  input logic sck,
  input logic mosiOe,
  input logic ssN,
  input logic busy
);
  // R1 / R11: disabled means idle pins in the same cycle
  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (ssN && sck && !mosiOe && !busy));

  // R1: the clock never drops while the slave is deselected
  assert_sck_high_when_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> sck);

  // R4: a low sck only occurs inside a frame with MOSI driven
  assert_low_sck_in_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    !sck |-> (!ssN && mosiOe));

  // R2: a frame starts only with a queued word and enable set
  assert_start_needs_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> $past(!txEmpty && enable));

  // R10: overrun appears only when the receive side was full
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxFull));

  // R10: overrun is sticky while enabled
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && enable) |=> rxOverrun);

  // R9: full and empty never together
  assert_tx_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty));
endmodule

bind spi_frame_master spi_fm_checker chk (
  .clk(clk), .rstN(rstN), .enable(enable), .txEmpty(txEmpty), .txFull(txFull),
  .rxFull(rxFull), .rxOverrun(rxOverrun), .sck(sck), .mosiOe(mosiOe),
  .ssN(ssN), .busy(busy)
);

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;
  logic clk = 0, rstN = 0, enable = 0;
  logic [7:0]  divider = 8'd1;
  logic [4:0]  wordLen = 5'd8;
  logic [15:0] txData = '0;
  logic txWrite = 0, rxRead = 0, miso = 0;
  logic txFull, txEmpty, rxFull, rxEmpty, rxOverrun, sck, mosi, mosiOe, ssN, busy;
  logic [15:0] rxData;

  spi_frame_master uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider), .wordLen(wordLen),
    .txData(txData), .txWrite(txWrite), .txFull(txFull), .txEmpty(txEmpty),
    .rxData(rxData), .rxRead(rxRead), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxOverrun(rxOverrun), .sck(sck), .mosi(mosi), .mosiOe(mosiOe), .ssN(ssN),
    .miso(miso), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // slave model and line monitor
  logic [15:0] slvArr [16];
  int slvPos = 0, slvLen = 8, slvIdx = 0;
  logic [15:0] slvCur = '0;
  logic [15:0] capWord = '0;
  logic [15:0] capLog [16];
  int capCnt = 0, capCntLog [16], frames = 0;
  realtime tSsFall = 0, tSsRise = 0, tFirstFall = 0, tLastFall = 0;
  realtime gapLog [16];

  initial forever begin
    @(negedge ssN);
    slvCur = slvArr[slvPos % 16];
    slvPos++;
    slvIdx = slvLen - 1;
    miso = slvCur[slvIdx];
    if (frames > 0 && frames < 16) gapLog[frames] = $realtime - tSsRise;
    tSsFall = $realtime;
    capCnt = 0;
    capWord = '0;
    frames++;
  end

  initial forever begin
    @(posedge sck);
    if (!ssN && slvIdx > 0) begin
      slvIdx--;
      miso = slvCur[slvIdx];
    end
  end

  initial forever begin
    @(negedge sck);
    if (!ssN) begin
      capWord = {capWord[14:0], mosi};
      capCnt++;
      if (capCnt == 1) tFirstFall = $realtime;
      tLastFall = $realtime;
    end
  end

  initial forever begin
    @(posedge ssN);
    tSsRise = $realtime;
    if (frames > 0 && frames <= 16) begin
      capLog[frames-1] = capWord;
      capCntLog[frames-1] = capCnt;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushTx(input logic [15:0] w);
    @(negedge clk);
    txData = w; txWrite = 1;
    @(negedge clk);
    txWrite = 0;
  endtask

  task automatic popRx(output logic [15:0] w);
    @(negedge clk);
    w = rxData; rxRead = 1;
    @(negedge clk);
    rxRead = 0;
  endtask

  task automatic waitQuiet();
    int quiet = 0;
    while (quiet < 24) begin
      @(negedge clk);
      if (ssN && txEmpty && !busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic startTest();
    frames = 0; slvPos = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset ssN", ssN, 1);
    check("R1 reset sck", sck, 1);
    check("R1 reset mosiOe", mosiOe, 0);
    check("R1 reset busy", busy, 0);
    check("R9 reset txEmpty", txEmpty, 1);
    check("R10 reset rxEmpty", rxEmpty, 1);
  endtask

  task automatic testSingle();
    logic [15:0] got;
    startTest();
    divider = 1; wordLen = 8; slvLen = 8; slvArr[0] = 16'h3C;
    enable = 1;
    repeat (10) @(negedge clk);
    check("R2 no start when tx empty", ssN, 1);
    pushTx(16'hA5);
    @(negedge ssN);
    #1;
    check("R1 mosiOe in frame", mosiOe, 1);
    check("R1 busy in frame", busy, 1);
    check("R3 mosi held low in first half", mosi, 0);
    waitQuiet();
    check("R4 mosi word", capLog[0], 16'hA5);
    check("R4 bit count", capCntLog[0], 8);
    check("R3 ssN fall to first sck fall", int'(tFirstFall - tSsFall), 20);
    check("R6 last fall to ssN rise", int'(tSsRise - tLastFall), 20);
    check("R4 miso word received", rxData, 16'h3C);
    popRx(got);
    check("R10 rx empty after read", rxEmpty, 1);
  endtask

  task automatic testLengths();
    logic [15:0] got;
    startTest();
    divider = 1;
    wordLen = 4; slvLen = 4; slvArr[0] = 16'hFFFF;
    pushTx(16'h0009); waitQuiet();
    check("R4 4-bit mosi", capLog[0], 16'h9);
    popRx(got);
    check("R5 right-justified 4-bit", got, 16'h000F);
    wordLen = 16; slvLen = 16; slvArr[1] = 16'hBEEF;
    pushTx(16'h1234); waitQuiet();
    check("R4 16-bit mosi", capLog[1], 16'h1234);
    popRx(got);
    check("R5 16-bit received", got, 16'hBEEF);
    wordLen = 2; slvLen = 4; slvArr[2] = 16'h000A;
    pushTx(16'h0005); waitQuiet();
    check("R5 len below 4 clamps", capCntLog[2], 4);
    popRx(got);
    check("R5 clamped receive", got, 16'h000A);
    wordLen = 20; slvLen = 16; slvArr[3] = 16'h8001;
    pushTx(16'hC3C3); waitQuiet();
    check("R5 len above 16 clamps", capCntLog[3], 16);
    popRx(got);
    check("R5 clamped 16 receive", got, 16'h8001);
  endtask

  task automatic testContinuous();
    logic [15:0] got;
    startTest();
    divider = 1; wordLen = 8; slvLen = 8;
    slvArr[0] = 16'h11; slvArr[1] = 16'h22; slvArr[2] = 16'h33;
    pushTx(16'hA1); pushTx(16'hB2); pushTx(16'hC3);
    waitQuiet();
    check("R7 three frames", frames, 3);
    check("R7 gap 1", int'(gapLog[1]), 20);
    check("R7 gap 2", int'(gapLog[2]), 20);
    check("R4 word 2 mosi", capLog[1], 16'hB2);
    check("R4 word 3 mosi", capLog[2], 16'hC3);
    for (int i = 0; i < 3; i++) begin
      popRx(got);
      check("R7 receive order", got, 16'h11 * (i + 1));
    end
  endtask

  task automatic testDivider();
    startTest();
    wordLen = 8; slvLen = 8;
    divider = 0;
    pushTx(16'h55); waitQuiet();
    check("R8 divider 0 acts as 1", int'(tFirstFall - tSsFall), 20);
    divider = 3;
    pushTx(16'h66);
    @(negedge ssN);
    @(negedge clk);
    divider = 0;
    waitQuiet();
    check("R8 half period 4 clocks", int'(tFirstFall - tSsFall), 40);
    check("R8 divider change ignored mid-frame", int'(tSsRise - tLastFall), 40);
    divider = 1;
    rxRead = 1; repeat (2) @(negedge clk); rxRead = 0;
  endtask

  task automatic testFifo();
    logic [15:0] got;
    startTest();
    enable = 0; divider = 1; wordLen = 8; slvLen = 8;
    for (int i = 0; i < 9; i++) slvArr[i] = 16'h40 + 16'(i);
    for (int i = 0; i < 8; i++) pushTx(16'h80 + 16'(i));
    check("R9 txFull at 8", txFull, 1);
    pushTx(16'hEE);
    enable = 1;
    waitQuiet();
    check("R9 ninth write ignored", frames, 8);
    check("R10 rxFull", rxFull, 1);
    check("R9 last mosi word", capLog[7], 16'h87);
    pushTx(16'h99); waitQuiet();
    check("R10 overrun set", rxOverrun, 1);
    for (int i = 0; i < 8; i++) begin
      popRx(got);
      check("R10 stored word intact", got, 16'h40 + 16'(i));
    end
    check("R10 extra word dropped", rxEmpty, 1);
    check("R10 overrun sticky", rxOverrun, 1);
    @(negedge clk); enable = 0;
    @(negedge clk); @(negedge clk);
    check("R10 overrun cleared by disable", rxOverrun, 0);
    enable = 1;
  endtask

  task automatic testAbort();
    startTest();
    divider = 3; wordLen = 16; slvLen = 16; slvArr[0] = 16'hFFFF;
    pushTx(16'hAAAA);
    @(negedge sck);
    @(negedge clk);
    enable = 0;
    #1;
    check("R11 ssN idle at once", ssN, 1);
    check("R11 sck idle at once", sck, 1);
    check("R11 mosiOe released", mosiOe, 0);
    check("R11 busy cleared", busy, 0);
    repeat (4) @(negedge clk);
    enable = 1;
    repeat (60) @(negedge clk);
    check("R11 no partial word stored", rxEmpty, 1);
    check("R2 no restart with empty tx", ssN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSingle();
    testLengths();
    testContinuous();
    testDivider();
    testFifo();
    testAbort();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule